// File: doc/BRIEF.md
# Hierarchical Page Table Walker

This block turns a virtual address into a physical address by walking a tree of translation tables held in memory. The page-number part of the virtual address is cut into equal index fields, one per tree level. Starting from a root table whose base address comes with the request, the walker reads one entry per level through a single read port. Each present entry names the page that holds the next table. At the last level it names the physical frame.

A walk ends in one of two ways. It succeeds at the last level, and the frame is joined to the unchanged page offset. Or it stops at the first entry whose presence bit is clear, and the response carries a fault flag and the level where the walk stopped. Only one walk runs at a time, and only one table read is ever in flight. The tree depth, the index width, the offset width and the address width are parameters. The default is two levels of 10-bit indices over 4 KB pages with 32-bit entries.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and in the first cycle after it, req_ready is 1, mem_rd_valid is 0 and rsp_valid is 0.
- R2: The read for level l (0 = root) goes to the current table base plus 4 times index field l. Field 0 is the topmost index field (VA bits [31:22] by default) and the last field sits just above the offset (bits [21:12]). Level 0 uses root_base.
- R3: A table entry is 32 bits. Bit 0 is the presence flag, bits [31:12] hold a page number and bits [11:1] are ignored. After a present entry that is not at the last level, the next table base is that page number followed by 12 zero bits.
- R4: A walk that finds present entries at every level returns rsp_fault = 0, rsp_level = LEVELS-1, and rsp_pa = {last entry bits [31:12], VA bits [11:0]}.
- R5: An entry with bit 0 clear at level l ends the walk. No further reads are issued, and the response carries rsp_fault = 1, rsp_level = l and rsp_pa = 0, even when the entry's other bits are non-zero.
- R6: Each level raises mem_rd_valid for exactly one cycle. No new read is issued, and no response given, until the returned word has been taken and checked. The returned word may arrive any number of cycles after the read.
- R7: rsp_valid is a single-cycle pulse. req_ready is 1 again in the following cycle.
- R8: A request is taken only when req_valid and req_ready are both 1. A request offered while a walk is running, including the response cycle, starts nothing.
- R9: mem_rd_data_valid is ignored unless a read is outstanding. A word offered in the issue cycle or in the cycle after the data arrived does not change the result.
- R10: root_base and req_va are sampled when the request is taken. Changing them during the walk has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_va | input | VA_W (32) | Virtual address to translate |
| root_base | input | PA_W (32) | Base address of the root table |
| mem_rd_valid | output | 1 | Table entry read issued this cycle |
| mem_rd_addr | output | PA_W (32) | Byte address of the entry, meaningful with mem_rd_valid |
| mem_rd_data_valid | input | 1 | Entry word returned this cycle |
| mem_rd_data | input | PA_W (32) | Returned entry word |
| rsp_valid | output | 1 | One-cycle response pulse |
| rsp_fault | output | 1 | Walk stopped on an absent entry |
| rsp_level | output | LVL_W (1) | Level of the final or faulting entry |
| rsp_pa | output | PA_W (32) | Physical address on success, zero on fault |

## Verification
Two things can fall in the same cycle, and both are provoked on purpose. First, a new request can arrive while the response pulse is high. The bench raises req_valid in the response cycle and expects the pulse, req_ready low, and no read in the following two cycles. Second, a stray returned word can appear while no read is outstanding. The bench drives a garbage word with mem_rd_data_valid both in the issue cycle and in the check cycle, and it judges the result by the physical address and fault level against its own table walk. The reference model in the bench walks a sparse table image and compares the port values in every cycle of each walk.

// File: rtl/pt_walk_pkg.sv
package pt_walk_pkg;

  typedef enum logic [2:0] {
    WS_IDLE,
    WS_ISSUE,
    WS_WAIT,
    WS_CHECK,
    WS_DONE,
    WS_FAULT
  } walk_state_t;

  localparam int ENTRY_SHIFT = 2;

endpackage

// File: rtl/pt_addr_gen.sv
module pt_addr_gen #(
  parameter int LEVELS = 2,
  parameter int IDX_W  = 10,
  parameter int PA_W   = 32,
  parameter int LVL_W  = 1
) (
  input  logic [PA_W-1:0]         table_base,
  input  logic [LEVELS*IDX_W-1:0] vpn,
  input  logic [LVL_W-1:0]        level,
  output logic [PA_W-1:0]         entry_addr
);
  import pt_walk_pkg::*;

  localparam int VPN_W = LEVELS * IDX_W;

  logic [IDX_W-1:0] idx_f [LEVELS];
  logic [IDX_W-1:0] idx_sel;

  // level 0 takes the most significant field
  for (genvar g = 0; g < LEVELS; g++) begin : g_field
    assign idx_f[g] = vpn[VPN_W-1-g*IDX_W -: IDX_W];
  end

  assign idx_sel = idx_f[level];

  function automatic logic [PA_W-1:0] slot_addr(input logic [PA_W-1:0] base,
                                                input logic [IDX_W-1:0] idx);
    logic [PA_W-1:0] off;
    off = PA_W'(idx) << ENTRY_SHIFT;
    return base + off;
  endfunction

  assign entry_addr = slot_addr(table_base, idx_sel);

endmodule

// File: rtl/pt_entry_check.sv
module pt_entry_check #(
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
) (
  input  logic [PA_W-1:0]       entry,
  output logic                  present,
  output logic [PA_W-OFF_W-1:0] frame,
  output logic [PA_W-1:0]       next_base
);
  localparam int PPN_W = PA_W - OFF_W;

  function automatic logic [PPN_W-1:0] frame_of(input logic [PA_W-1:0] e);
    return e[PA_W-1:OFF_W];
  endfunction

  logic unused_attr_bits;

  assign present          = entry[0];
  assign frame            = frame_of(entry);
  assign next_base        = {frame_of(entry), {OFF_W{1'b0}}};
  assign unused_attr_bits = ^entry[OFF_W-1:1];

endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int LEVELS = 2,
  parameter int IDX_W  = 10,
  parameter int OFF_W  = 12,
  parameter int PA_W   = 32,
  localparam int VA_W  = LEVELS * IDX_W + OFF_W,
  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_va,
  input  logic [PA_W-1:0]  root_base,
  output logic             mem_rd_valid,
  output logic [PA_W-1:0]  mem_rd_addr,
  input  logic             mem_rd_data_valid,
  input  logic [PA_W-1:0]  mem_rd_data,
  output logic             rsp_valid,
  output logic             rsp_fault,
  output logic [LVL_W-1:0] rsp_level,
  output logic [PA_W-1:0]  rsp_pa
);
  import pt_walk_pkg::*;

  localparam int PPN_W = PA_W - OFF_W;
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS - 1);

  walk_state_t      st_q, st_d;
  logic [LVL_W-1:0] lvl_q;
  logic [VA_W-1:0]  va_q;
  logic [PA_W-1:0]  base_q;
  logic [PA_W-1:0]  entry_q;

  logic             ent_present;
  logic [PPN_W-1:0] ent_frame;
  logic [PA_W-1:0]  ent_next_base;
  logic [PA_W-1:0]  rd_addr;

  // named events, also observed by the bound checker
  logic walk_accept, entry_arrives, entry_null, walk_descend, walk_finish, at_last;

  assign at_last       = (lvl_q == LAST_LVL);
  assign walk_accept   = req_valid && (st_q == WS_IDLE);
  assign entry_arrives = mem_rd_data_valid && (st_q == WS_WAIT);
  assign entry_null    = (st_q == WS_CHECK) && !ent_present;
  assign walk_descend  = (st_q == WS_CHECK) && ent_present && !at_last;
  assign walk_finish   = (st_q == WS_CHECK) && ent_present && at_last;

  pt_addr_gen #(
    .LEVELS(LEVELS), .IDX_W(IDX_W), .PA_W(PA_W), .LVL_W(LVL_W)
  ) u_addr_gen (
    .table_base (base_q),
    .vpn        (va_q[VA_W-1:OFF_W]),
    .level      (lvl_q),
    .entry_addr (rd_addr)
  );

  pt_entry_check #(
    .PA_W(PA_W), .OFF_W(OFF_W)
  ) u_entry_check (
    .entry     (entry_q),
    .present   (ent_present),
    .frame     (ent_frame),
    .next_base (ent_next_base)
  );

  always_comb begin
    st_d = st_q;
    case (st_q)
      WS_IDLE:  if (walk_accept)   st_d = WS_ISSUE;
      WS_ISSUE:                    st_d = WS_WAIT;
      WS_WAIT:  if (entry_arrives) st_d = WS_CHECK;
      WS_CHECK: begin
        if (entry_null)        st_d = WS_FAULT;
        else if (walk_finish)  st_d = WS_DONE;
        else                   st_d = WS_ISSUE;
      end
      WS_DONE:                     st_d = WS_IDLE;
      WS_FAULT:                    st_d = WS_IDLE;
      default:                     st_d = WS_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= WS_IDLE;
      lvl_q   <= '0;
      va_q    <= '0;
      base_q  <= '0;
      entry_q <= '0;
    end else begin
      st_q <= st_d;
      if (walk_accept) begin
        va_q   <= req_va;
        base_q <= root_base;
        lvl_q  <= '0;
      end
      if (entry_arrives) entry_q <= mem_rd_data;
      if (walk_descend) begin
        base_q <= ent_next_base;
        lvl_q  <= lvl_q + 1'b1;
      end
    end
  end

  assign req_ready    = (st_q == WS_IDLE);
  assign mem_rd_valid = (st_q == WS_ISSUE);
  assign mem_rd_addr  = rd_addr;
  assign rsp_valid    = (st_q == WS_DONE) || (st_q == WS_FAULT);
  assign rsp_fault    = (st_q == WS_FAULT);
  assign rsp_level    = rsp_valid ? lvl_q : '0;
  assign rsp_pa       = (st_q == WS_DONE) ? {ent_frame, va_q[OFF_W-1:0]} : '0;

endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int PA_W = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_ready,
  input logic            mem_rd_valid,
  input logic            mem_rd_data_valid,
  input logic            rsp_valid,
  input logic            rsp_fault,
  input logic [PA_W-1:0] rsp_pa,
  input logic            walk_accept
);
  logic outstanding;

  always_ff @(posedge clk) begin
    if (!rst_n)                 outstanding <= 1'b0;
    else if (mem_rd_valid)      outstanding <= 1'b1;
    else if (mem_rd_data_valid) outstanding <= 1'b0;
  end

  AST_SINGLE_ISSUE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |=> !mem_rd_valid); // R6
  AST_NO_SECOND_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_valid |-> !outstanding); // R6
  AST_NO_RSP_WHILE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !outstanding); // R6
  AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready)); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (!mem_rd_valid && !rsp_valid)); // R8
  AST_ACCEPT_STARTS_READ: assert property (@(posedge clk) disable iff (!rst_n)
    walk_accept |=> (mem_rd_valid && !req_ready)); // R2
  AST_FAULT_NO_PA: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_pa == '0)); // R5

endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_pt_walker_chk (
  .clk               (clk),
  .rst_n             (rst_n),
  .req_ready         (req_ready),
  .mem_rd_valid      (mem_rd_valid),
  .mem_rd_data_valid (mem_rd_data_valid),
  .rsp_valid         (rsp_valid),
  .rsp_fault         (rsp_fault),
  .rsp_pa            (rsp_pa),
  .walk_accept       (walk_accept)
);

// File: tb/pt_walker_bench.sv
module pt_walker_bench;
  localparam int LEVELS = 2;
  localparam int IDX_W  = 10;
  localparam int OFF_W  = 12;
  localparam int PA_W   = 32;
  localparam int VA_W   = 32;
  localparam int LVL_W  = 1;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic             rst_n = 1'b0;
  logic             req_valid = 1'b0;
  logic             req_ready;
  logic [VA_W-1:0]  req_va = '0;
  logic [PA_W-1:0]  root_base = '0;
  logic             mem_rd_valid;
  logic [PA_W-1:0]  mem_rd_addr;
  logic             mem_rd_data_valid = 1'b0;
  logic [PA_W-1:0]  mem_rd_data = '0;
  logic             rsp_valid;
  logic             rsp_fault;
  logic [LVL_W-1:0] rsp_level;
  logic [PA_W-1:0]  rsp_pa;

  int checks = 0;
  int errors = 0;
  logic [31:0] pt_mem [int unsigned];

  pt_walker u_pt_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_va(req_va), .root_base(root_base), .mem_rd_valid(mem_rd_valid),
    .mem_rd_addr(mem_rd_addr), .mem_rd_data_valid(mem_rd_data_valid),
    .mem_rd_data(mem_rd_data), .rsp_valid(rsp_valid), .rsp_fault(rsp_fault),
    .rsp_level(rsp_level), .rsp_pa(rsp_pa)
  );

  task automatic chk(input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] rd(input logic [31:0] a);
    return pt_mem.exists(a) ? pt_mem[a] : 32'h0;
  endfunction

  function automatic logic [31:0] field(input logic [31:0] va, input int l);
    return (va >> (OFF_W + (LEVELS - 1 - l) * IDX_W)) & ((32'd1 << IDX_W) - 1);
  endfunction

  // one complete walk, compared port by port in every cycle
  task automatic walk(input logic [31:0] va, input logic [31:0] root, input int lat,
                      input bit stray, input bit overlap, input logic [31:0] alt_root);
    logic [31:0] base;
    logic [31:0] ent;
    logic [31:0] addr;
    bit fault;
    int flvl;
    base  = root;
    ent   = '0;
    fault = 1'b0;
    flvl  = LEVELS - 1;
    chk("R8", "ready before request", req_ready, 1);
    req_valid = 1'b1; req_va = va; root_base = root;
    @(negedge clk);
    req_valid = 1'b0; root_base = alt_root; req_va = ~va;   // R10
    for (int l = 0; l < LEVELS; l++) begin
      addr = base + (field(va, l) << 2);
      chk("R6", "read issued", mem_rd_valid, 1);
      chk("R2", "entry address", mem_rd_addr, addr);
      chk("R8", "busy not ready", req_ready, 0);
      ent = rd(addr);
      if (stray) begin mem_rd_data_valid = 1'b1; mem_rd_data = 32'hDEAD_B000; end // R9
      @(negedge clk);
      mem_rd_data_valid = 1'b0;
      for (int w = 0; w < lat; w++) begin
        chk("R6", "no reissue while waiting", mem_rd_valid, 0);
        chk("R6", "no response while waiting", rsp_valid, 0);
        @(negedge clk);
      end
      chk("R6", "still waiting", mem_rd_valid, 0);
      mem_rd_data_valid = 1'b1; mem_rd_data = ent;
      @(negedge clk);
      mem_rd_data_valid = 1'b0; mem_rd_data = '0;
      if (stray) begin mem_rd_data_valid = 1'b1; mem_rd_data = 32'h0000_0000; end // R9
      chk("R6", "check cycle quiet", mem_rd_valid, 0);
      chk("R6", "check cycle no rsp", rsp_valid, 0);
      @(negedge clk);
      mem_rd_data_valid = 1'b0;
      if (!ent[0]) begin fault = 1'b1; flvl = l; break; end
      base = {ent[31:12], 12'h000};   // R3
    end
    chk("R7", "response pulse", rsp_valid, 1);
    chk("R6", "no read with response", mem_rd_valid, 0);
    if (fault) begin
      chk("R5", "fault flag", rsp_fault, 1);
      chk("R5", "fault level", rsp_level, flvl);
      chk("R5", "fault pa zero", rsp_pa, 0);
    end else begin
      chk("R4", "no fault", rsp_fault, 0);
      chk("R4", "last level", rsp_level, LEVELS - 1);
      chk("R4", "physical address", rsp_pa, {ent[31:12], va[11:0]});
    end
    chk("R8", "not ready in response", req_ready, 0);
    if (overlap) begin req_valid = 1'b1; req_va = va; root_base = root; end
    @(negedge clk);
    req_valid = 1'b0;
    chk("R7", "pulse ends", rsp_valid, 0);
    chk("R7", "ready after response", req_ready, 1);
    chk("R8", "overlap ignored", mem_rd_valid, 0);
    @(negedge clk);
    chk("R8", "still no read", mem_rd_valid, 0);
  endtask

  localparam logic [31:0] ROOT  = 32'h0010_0000;
  localparam logic [31:0] ROOT2 = 32'h0080_0000;

  function automatic logic [31:0] mkva(input int i0, input int i1, input int off);
    return {i0[9:0], i1[9:0], off[11:0]};
  endfunction

  initial begin
    pt_mem[ROOT + 3*4]             = 32'h0020_0001;
    pt_mem[32'h0020_0000 + 5*4]    = 32'h1234_5001;
    pt_mem[32'h0020_0000 + 6*4]    = 32'h0000_0000;
    pt_mem[32'h0020_0000 + 9*4]    = 32'h7777_7FFE;
    pt_mem[ROOT + 1023*4]          = 32'h0030_0001;
    pt_mem[32'h0030_0000 + 1023*4] = 32'hFEDC_BFFF;
    pt_mem[ROOT]                   = 32'h0040_0001;
    pt_mem[32'h0040_0000]          = 32'h0000_1001;
    pt_mem[ROOT + 8*4]             = 32'h0050_0FFE;
    pt_mem[ROOT2 + 3*4]            = 32'h0060_0001;
    pt_mem[32'h0060_0000 + 5*4]    = 32'hABCD_E001;

    repeat (2) @(negedge clk);
    chk("R1", "ready in reset", req_ready, 1);
    chk("R1", "no read in reset", mem_rd_valid, 0);
    chk("R1", "no rsp in reset", rsp_valid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", req_ready, 1);
    chk("R1", "no rsp after reset", rsp_valid, 0);

    walk(mkva(3, 5, 'hABC), ROOT, 0, 0, 0, ROOT2);        // R4 R10
    walk(mkva(3, 5, 'h123), ROOT2, 3, 0, 0, ROOT);        // R10 R6
    walk(mkva(1023, 1023, 'hFFF), ROOT, 1, 0, 0, ROOT);   // R2 upper edge, R3
    walk(mkva(0, 0, 0), ROOT, 2, 0, 0, ROOT);             // R2 lower edge
    walk(mkva(7, 0, 'h010), ROOT, 0, 0, 0, ROOT);         // R5 level 0
    walk(mkva(8, 2, 'h010), ROOT, 1, 0, 0, ROOT);         // R5 junk bits
    walk(mkva(3, 6, 'h444), ROOT, 2, 0, 0, ROOT);         // R5 level 1
    walk(mkva(3, 9, 'h444), ROOT, 0, 0, 0, ROOT);         // R5 junk bits
    walk(mkva(3, 5, 'h777), ROOT, 2, 1, 0, ROOT);         // R9 stray data
    walk(mkva(1023, 1023, 'h001), ROOT, 0, 1, 1, ROOT2);  // R8 R9 overlap
    walk(mkva(7, 1, 'h000), ROOT, 1, 0, 1, ROOT);         // R8 overlap on fault

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule